// File: doc/BRIEF.md
# Iterative Integer Multiply/Divide Unit

This unit sits beside the execute stage of an in-order pipeline and performs 32-bit integer multiplication and division over many clock cycles. The pipeline hands it two operands and an operation code in a single cycle and then carries on with other instructions while the unit works. Results do not use the shared register-file write port. They land in two private result registers: a high word and a low word.

Multiplication uses a radix-2 shift-and-add loop and division uses a restoring shift-and-subtract loop. Each loop runs one step per cycle for W steps, followed by one cycle that corrects the signs and writes the results. Signed operands are converted to magnitudes on entry. The result signs are applied on exit. A busy flag tells the issue logic to hold back reads of the result registers, and any new operation, until the results are in place. Requests that arrive while the unit is busy are dropped.

Top module: `muldiv_iter`

## Requirements
- R1: With `op` = 2'b00 (bit 1 selects divide, bit 0 selects signed), the full 2W-bit unsigned product of `src_a` and `src_b` appears with its upper half on `hi` and its lower half on `lo`.
- R2: With `op` = 2'b01 the operands are two's-complement values, and `{hi, lo}` holds the signed 2W-bit product.
- R3: With `op` = 2'b10 the unsigned quotient `src_a / src_b` appears on `lo` and the remainder on `hi`.
- R4: With `op` = 2'b11 the quotient is truncated toward zero and the remainder carries the sign of the dividend. A most-negative dividend divided by -1 gives a quotient equal to the most-negative value and a remainder of zero.
- R5: A divide with `src_b` = 0, signed or unsigned, takes the normal cycle count. It leaves all ones on `lo` and the unmodified dividend on `hi`.
- R6: A `start` sampled with `busy` low is accepted. `busy` then reads high for exactly W+1 cycles after the accepting edge, and `hi`/`lo` take the new results on the edge where `busy` falls.
- R7: A `start` sampled while `busy` is high is ignored. This includes the final busy cycle. Such a request does not restart or lengthen the running operation, does not alter its result, and leaves no operation pending.
- R8: While `busy` is high, `hi` and `lo` keep the results of the previous operation.
- R9: While `rst` is high, `busy`, `hi` and `lo` are driven to zero at each clock edge. This also aborts any operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin an operation |
| op | input | 2 | Bit 1: divide (1) / multiply (0); bit 0: signed (1) / unsigned (0) |
| src_a | input | W | Multiplicand or dividend |
| src_b | input | W | Multiplier or divisor |
| busy | output | 1 | Operation in progress; results not yet valid |
| hi | output | W | High product word or remainder |
| lo | output | W | Low product word or quotient |

## Verification
Two events can fall in the same cycle: the write of a finished result, and a new `start` arriving on the edge where `busy` falls. The bench provokes this by holding `start` high, with a different operation on the inputs, through every busy cycle. It releases `start` in the first cycle where `busy` reads low. It then confirms three things: the running result is not replaced, `busy` stays low afterwards, and an immediate later request is accepted normally. Further cases cover sign combinations, the most-negative operand, and division by zero. For each operation the bench counts the busy cycles and compares the held result registers on every one of them.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef struct packed {
    logic is_div;
    logic neg_lo;
    logic neg_hi;
    logic div0;
  } md_fix_t;
endpackage

// File: rtl/muldiv_prep.sv
module muldiv_prep
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [1:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] mag_a,
  output logic [W-1:0] mag_b,
  output md_fix_t      fix
);
  logic sa, sb;

  always_comb begin
    sa         = op[0] & a[W-1];
    sb         = op[0] & b[W-1];
    mag_a      = sa ? (~a + W'(1)) : a;
    mag_b      = sb ? (~b + W'(1)) : b;
    fix.is_div = op[1];
    fix.neg_lo = sa ^ sb;
    fix.neg_hi = op[1] & sa;
    fix.div0   = op[1] & (b == '0);
  end
endmodule

// File: rtl/muldiv_engine.sv
module muldiv_engine #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         is_div,
  input  logic [W-1:0] mag_a,
  input  logic [W-1:0] mag_b,
  output logic         busy,
  output logic         fin,
  output logic [W-1:0] acc,
  output logic [W-1:0] quo
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt;
  logic [W-1:0]  m;
  logic [W:0]    add_s;
  logic [W:0]    sh;
  logic          ge;
  logic [W-1:0]  diff;

  always_comb begin
    add_s = {1'b0, acc} + (quo[0] ? {1'b0, m} : '0);
    sh    = {acc, quo[W-1]};
    ge    = sh >= {1'b0, m};
    diff  = sh[W-1:0] - m;
    fin   = busy && (cnt == CW'(W));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      acc  <= '0;
      quo  <= '0;
      m    <= '0;
    end else if (load) begin
      busy <= 1'b1;
      cnt  <= '0;
      acc  <= '0;
      quo  <= mag_a;
      m    <= mag_b;
    end else if (busy) begin
      if (fin) begin
        busy <= 1'b0;
      end else begin
        cnt <= cnt + CW'(1);
        if (is_div) begin
          acc <= ge ? diff : sh[W-1:0];
          quo <= {quo[W-2:0], ge};
        end else begin
          acc <= add_s[W:1];
          quo <= {add_s[0], quo[W-1:1]};
        end
      end
    end
  end

  // R6
  fin_clears_chk: assert property (@(posedge clk) disable iff (rst)
    fin |=> !busy);

  // R6
  step_count_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !fin) |=> (busy && (cnt == $past(cnt) + CW'(1))));
endmodule

// File: rtl/muldiv_fixup.sv
module muldiv_fixup
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  md_fix_t      fix,
  input  logic [W-1:0] dvd,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] quo,
  output logic [W-1:0] res_hi,
  output logic [W-1:0] res_lo
);
  logic [2*W-1:0] prod;

  always_comb begin
    prod = fix.neg_lo ? (~{acc, quo} + (2*W)'(1)) : {acc, quo};
    if (!fix.is_div) begin
      res_hi = prod[2*W-1:W];
      res_lo = prod[W-1:0];
    end else if (fix.div0) begin
      res_hi = dvd;
      res_lo = '1;
    end else begin
      res_hi = fix.neg_hi ? (~acc + W'(1)) : acc;
      res_lo = fix.neg_lo ? (~quo + W'(1)) : quo;
    end
  end
endmodule

// File: rtl/muldiv_iter.sv
module muldiv_iter
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  output logic         busy,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  logic         load;
  logic         fin;
  logic [W-1:0] mag_a, mag_b;
  logic [W-1:0] acc, quo;
  logic [W-1:0] res_hi, res_lo;
  logic [W-1:0] dvd_q;
  md_fix_t      fix, fix_q;

  assign load = start & ~busy;

  muldiv_prep #(.W(W)) u_prep (
    .op(op), .a(src_a), .b(src_b),
    .mag_a(mag_a), .mag_b(mag_b), .fix(fix)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fix_q <= '0;
      dvd_q <= '0;
    end else if (load) begin
      fix_q <= fix;
      dvd_q <= src_a;
    end
  end

  muldiv_engine #(.W(W)) u_engine (
    .clk(clk), .rst(rst), .load(load), .is_div(fix_q.is_div),
    .mag_a(mag_a), .mag_b(mag_b),
    .busy(busy), .fin(fin), .acc(acc), .quo(quo)
  );

  muldiv_fixup #(.W(W)) u_fixup (
    .fix(fix_q), .dvd(dvd_q), .acc(acc), .quo(quo),
    .res_hi(res_hi), .res_lo(res_lo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hi <= '0;
      lo <= '0;
    end else if (fin) begin
      hi <= res_hi;
      lo <= res_lo;
    end
  end

  // R6
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R7
  ignore_start_chk: assert property (@(posedge clk) disable iff (rst)
    (start && busy) |=> ($stable(fix_q) && $stable(dvd_q)));

  // R8
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(hi) && $stable(lo)));

  // R5
  div_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (fin && fix_q.div0) |=> ((lo == '1) && (hi == $past(dvd_q))));

  // R9
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!busy && (hi == '0) && (lo == '0)));
endmodule

// File: tb/muldiv_iter_test.sv
module muldiv_iter_test;
  localparam int W  = 32;
  localparam int NV = 15;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [1:0]   op = '0;
  logic [W-1:0] src_a = '0, src_b = '0;
  logic         busy;
  logic [W-1:0] hi, lo;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  muldiv_iter #(.W(W)) uut (
    .clk(clk), .rst(rst), .start(start), .op(op),
    .src_a(src_a), .src_b(src_b), .busy(busy), .hi(hi), .lo(lo)
  );

  // {op, a, b, expected hi, expected lo}
  localparam logic [129:0] VEC [NV] = '{
    {2'b00, 32'h00000003, 32'h00000005, 32'h00000000, 32'h0000000F},
    {2'b00, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFE, 32'h00000001},
    {2'b00, 32'h00010000, 32'h00010000, 32'h00000001, 32'h00000000},
    {2'b00, 32'h12345678, 32'h00000000, 32'h00000000, 32'h00000000},
    {2'b01, 32'hFFFFFFFE, 32'h00000003, 32'hFFFFFFFF, 32'hFFFFFFFA},
    {2'b01, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 32'h00000001},
    {2'b01, 32'h80000000, 32'h00000002, 32'hFFFFFFFF, 32'h00000000},
    {2'b10, 32'h00000064, 32'h00000007, 32'h00000002, 32'h0000000E},
    {2'b10, 32'hFFFFFFFF, 32'h00000002, 32'h00000001, 32'h7FFFFFFF},
    {2'b11, 32'hFFFFFFF9, 32'h00000002, 32'hFFFFFFFF, 32'hFFFFFFFD},
    {2'b11, 32'h00000007, 32'hFFFFFFFE, 32'h00000001, 32'hFFFFFFFD},
    {2'b11, 32'hFFFFFFF9, 32'hFFFFFFFE, 32'hFFFFFFFF, 32'h00000003},
    {2'b11, 32'h80000000, 32'hFFFFFFFF, 32'h00000000, 32'h80000000},
    {2'b10, 32'h00000005, 32'h00000000, 32'h00000005, 32'hFFFFFFFF},
    {2'b11, 32'hFFFFFFF9, 32'h00000000, 32'hFFFFFFF9, 32'hFFFFFFFF}
  };

  function automatic string req_of(input logic [1:0] o, input logic [W-1:0] b);
    if (o[1] && b == '0) return "R5";
    case (o)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Issue one operation and wait for it; checks latency, hold and result.
  task automatic run_op(input logic [1:0] o, input logic [W-1:0] a,
                        input logic [W-1:0] b, input logic [W-1:0] ehi,
                        input logic [W-1:0] elo);
    logic [W-1:0] phi, plo;
    int n, moved;
    phi = hi; plo = lo;
    @(negedge clk);
    start = 1'b1; op = o; src_a = a; src_b = b;
    @(negedge clk);
    start = 1'b0;
    check("R6", "busy after accept", W'(busy), W'(1));
    n = 0; moved = 0;
    while (busy && n < 200) begin
      if (hi !== phi || lo !== plo) moved++;
      n++;
      @(negedge clk);
    end
    check("R6", "busy cycle count", W'(n), W'(W + 1));
    check("R8", "hi/lo moved while busy", W'(moved), W'(0));
    check(req_of(o, b), "hi", hi, ehi);
    check(req_of(o, b), "lo", lo, elo);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int n;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", "busy in reset", W'(busy), W'(0));
    check("R9", "hi in reset", hi, '0);
    check("R9", "lo in reset", lo, '0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][129:128], VEC[i][127:96], VEC[i][95:64],
             VEC[i][63:32], VEC[i][31:0]);
    end

    // R7: start mid-operation ignored
    @(negedge clk);
    start = 1'b1; op = 2'b00; src_a = 32'd6; src_b = 32'd7;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    start = 1'b1; op = 2'b10; src_a = 32'd100; src_b = 32'd7;
    @(negedge clk);
    start = 1'b0;
    n = 6;
    while (busy && n < 200) begin n++; @(negedge clk); end
    check("R7", "mid-run start busy cycles", W'(n), W'(W + 1));
    check("R7", "mid-run start lo", lo, 32'd42);
    check("R7", "mid-run start hi", hi, 32'd0);
    @(negedge clk);
    check("R7", "no pending op", W'(busy), W'(0));

    // R7: start held through the final busy cycle collides with result write
    @(negedge clk);
    start = 1'b1; op = 2'b00; src_a = 32'd9; src_b = 32'd9;
    @(negedge clk);
    op = 2'b11; src_a = 32'h0000_0100; src_b = 32'd3;
    n = 0;
    while (busy && n < 200) begin n++; @(negedge clk); end
    start = 1'b0;
    check("R7", "collision busy cycles", W'(n), W'(W + 1));
    check("R7", "collision lo", lo, 32'd81);
    @(negedge clk);
    check("R7", "start on final edge dropped", W'(busy), W'(0));
    check("R7", "collision lo kept", lo, 32'd81);
    // next request right after is accepted
    run_op(2'b11, 32'h0000_0100, 32'd3, 32'd1, 32'd85);

    // R9: reset aborts an operation in progress
    @(negedge clk);
    start = 1'b1; op = 2'b00; src_a = 32'd2; src_b = 32'd2;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R9", "busy after abort", W'(busy), W'(0));
    check("R9", "hi after abort", hi, '0);
    check("R9", "lo after abort", lo, '0);
    rst = 1'b0;
    repeat (W + 4) @(negedge clk);
    check("R9", "aborted op never writes", lo, '0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule